// File: doc/BRIEF.md
# NAND Device Command Front End

This block is the device side of a multiplexed x8 NAND bus. It watches sampled, synchronous copies of chip enable, command latch, address latch, write strobe, read strobe and write protect. A rising write strobe with command latch high carries a command byte. With address latch high it carries an address byte. With both low it carries a data byte. A rising read strobe steps the output pointer. The block gathers multi-cycle addresses and runs the read, program, erase, random-column and cache-read sequences. It shows a busy flag for a fixed, parameterised number of cycles. It keeps track of which source drives the output bus: page data, the status byte or the identification bytes.

There is no memory array. A small register file stands in for the page buffer and is indexed by the low bits of the column pointer. Program data lands in that file. Array reads return it. The sequencer moves through these states: `ST_IDLE`, `ST_RD_ADDR`, `ST_RD_CONF`, `ST_PG_ADDR`, `ST_PG_DATA`, `ST_ER_ADDR`, `ST_ER_CONF`, `ST_COL_ADDR` and `ST_COL_CONF`.

The transitions are as follows:
- From `ST_IDLE`, 00h goes to `ST_RD_ADDR`, 80h goes to `ST_PG_ADDR`, 60h goes to `ST_ER_ADDR`, and 05h goes to `ST_COL_ADDR`.
- The last address byte moves each address state to its confirm state (`ST_PG_DATA` for program).
- The matching confirm byte (30h/31h, 10h, D0h, E0h) returns to `ST_IDLE`.
- Any other command byte in a confirm state is decoded as a fresh command.
- FFh returns to `ST_IDLE` from any state.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset, busy is low, the output source is page data, the column pointer is 0, and `io_out` reads 00h.
- R2: The status byte has bit 7 equal to the write-protect input (1 = writable), bit 6 equal to 1 when not busy, bit 0 equal to the fail flag, and all other bits 0. Command 70h selects the status byte. It stays selected across read strobes and across program and erase sequences until 00h, 90h, a completed E0h column change or FFh is written.
- R3: The sequence 00h, five address bytes (column low byte, then column high byte, then three row bytes), 30h loads the column pointer and raises busy for exactly BUSY_CYCLES cycles. Each read strobe in page-data mode then steps the column.
- R4: The sequence 80h, five address bytes, data bytes, 10h stores each data byte at the current column and steps the column. It then raises busy for BUSY_CYCLES cycles.
- R5: The sequence 60h, five address bytes, D0h raises busy for BUSY_CYCLES cycles and leaves the page buffer unchanged.
- R6: The sequence 05h, two column bytes, E0h moves the column pointer and selects page data without raising busy. It is refused while cache read is active.
- R7: The sequence 00h, five address bytes, 31h enters cache read with busy for BUSY_CYCLES cycles. Command 34h while cache read is active leaves it and raises busy.
- R8: After 90h the output shows ADh, then D3h after one read strobe, then 00h.
- R9: A 10h or D0h confirm with write protect low sets the fail flag and does not raise busy. The flag stays set until the next accepted program or erase start, or FFh.
- R10: During a program or erase, write protect held low for WP_FILT_CYC consecutive cycles ends busy on the following cycle and sets the fail flag. Shorter low pulses, and read operations, are not affected.
- R11: The column pointer wraps from PAGE_DATA+PAGE_SPARE-1 (2111 by default) to 0.
- R12: A command byte outside the recognised set leaves the output source, the state and the busy flag unchanged.
- R13: While busy, only 70h and FFh are acted on. FFh at any time clears busy, the fail flag, cache read and the column pointer, and selects page data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; strobes are ignored when high |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| we_n | input | 1 | Write strobe, acts on its rising edge |
| re_n | input | 1 | Read strobe, acts on its rising edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Bus byte written by the host |
| io_out | output | 8 | Bus byte returned to the host |
| busy | output | 1 | High while an operation is timing out |

## Verification
The assertions check on every cycle that:
- busy only rises one cycle after an accepted start;
- no start is issued while busy, and none follows an unrecognised command;
- an abort only occurs with write protect held low;
- the column pointer never leaves the page;
- the status source persists when no command is written.

Only the bench scenarios can show the complete sequences and their results. These are the busy duration, the data returned after program and read, the identification bytes, the refusal of a column change in cache read, the fail flag after a protected or aborted operation, and the glitch filter that lets a short write-protect dip pass.

// File: rtl/nfi_pkg.sv
package nfi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_CONF,
        ST_PG_ADDR,
        ST_PG_DATA,
        ST_ER_ADDR,
        ST_ER_CONF,
        ST_COL_ADDR,
        ST_COL_CONF
    } seq_state_t;

    typedef enum logic [1:0] {
        OUT_ARRAY,
        OUT_STATUS,
        OUT_IDENT
    } out_mode_t;

    localparam logic [7:0] OP_READ      = 8'h00;
    localparam logic [7:0] OP_READ_GO   = 8'h30;
    localparam logic [7:0] OP_CACHE_GO  = 8'h31;
    localparam logic [7:0] OP_CACHE_END = 8'h34;
    localparam logic [7:0] OP_COL       = 8'h05;
    localparam logic [7:0] OP_COL_GO    = 8'hE0;
    localparam logic [7:0] OP_PROG      = 8'h80;
    localparam logic [7:0] OP_PROG_GO   = 8'h10;
    localparam logic [7:0] OP_ERASE     = 8'h60;
    localparam logic [7:0] OP_ERASE_GO  = 8'hD0;
    localparam logic [7:0] OP_STATUS    = 8'h70;
    localparam logic [7:0] OP_IDENT     = 8'h90;
    localparam logic [7:0] OP_RESET     = 8'hFF;

    localparam logic [7:0] ID_MAKER  = 8'hAD;
    localparam logic [7:0] ID_DEVICE = 8'hD3;

    function automatic logic op_known(input logic [7:0] b);
        return (b == OP_READ) || (b == OP_READ_GO) || (b == OP_CACHE_GO) ||
               (b == OP_CACHE_END) || (b == OP_COL) || (b == OP_COL_GO) ||
               (b == OP_PROG) || (b == OP_PROG_GO) || (b == OP_ERASE) ||
               (b == OP_ERASE_GO) || (b == OP_STATUS) || (b == OP_IDENT) ||
               (b == OP_RESET);
    endfunction

endpackage

// File: rtl/nfi_strobe.sv
module nfi_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic cle,
    input  logic ale,
    input  logic we_n,
    input  logic re_n,
    output logic cmd_stb_o,
    output logic adr_stb_o,
    output logic dat_stb_o,
    output logic rd_stb_o
);
    logic we_d;
    logic re_d;
    logic we_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_d <= 1'b1;
            re_d <= 1'b1;
        end else begin
            we_d <= we_n;
            re_d <= re_n;
        end
    end

    assign we_rise   = !we_d && we_n && !ce_n;
    assign cmd_stb_o = we_rise && cle && !ale;
    assign adr_stb_o = we_rise && ale && !cle;
    assign dat_stb_o = we_rise && !ale && !cle;
    assign rd_stb_o  = !re_d && re_n && !ce_n;

endmodule

// File: rtl/nfi_busy_timer.sv
module nfi_busy_timer #(
    parameter int BUSY_CYCLES = 64,
    parameter int WP_FILT_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic wr_op_i,
    input  logic cancel_i,
    input  logic wp_n_i,
    output logic busy_o,
    output logic abort_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam int WPC_W = $clog2(WP_FILT_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [WPC_W-1:0] wp_lo_q;
    logic             wr_op_q;
    logic             wp_settled;

    assign busy_o     = (cnt_q != '0);
    assign wp_settled = (wp_lo_q == WPC_W'(WP_FILT_CYC));
    assign abort_o    = busy_o && wr_op_q && wp_settled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_lo_q <= '0;
        end else if (wp_n_i) begin
            wp_lo_q <= '0;
        end else if (!wp_settled) begin
            wp_lo_q <= wp_lo_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            wr_op_q <= 1'b0;
        end else if (cancel_i || abort_o) begin
            cnt_q   <= '0;
            wr_op_q <= 1'b0;
        end else if (start_i) begin
            cnt_q   <= CNT_W'(BUSY_CYCLES);
            wr_op_q <= wr_op_i;
        end else if (busy_o) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R3

    AST_ABORT_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (!wp_n_i && $past(!wp_n_i))); // R10

endmodule

// File: rtl/nfi_page_buf.sv
module nfi_page_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_idx_i,
    input  logic [7:0]    wr_data_i,
    input  logic [AW-1:0] rd_idx_i,
    output logic [7:0]    rd_data_o
);
    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= 8'h00;
            end
        end else if (wr_en_i) begin
            cells_q[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = cells_q[rd_idx_i];

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nfi_pkg::*;
#(
    parameter int PAGE_DATA   = 2048,
    parameter int PAGE_SPARE  = 64,
    parameter int ADDR_CYC    = 5,
    parameter int COL_CYC     = 2,
    parameter int BUSY_CYCLES = 64,
    parameter int WP_FILT_CYC = 5,
    parameter int BUF_DEPTH   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       busy
);
    localparam int COL_TOTAL = PAGE_DATA + PAGE_SPARE;
    localparam int COL_W     = $clog2(COL_TOTAL);
    localparam int BUF_AW    = $clog2(BUF_DEPTH);
    localparam int ACNT_W    = $clog2(ADDR_CYC + 1);

    seq_state_t st_q, st_n;
    out_mode_t  mode_q;

    logic cmd_stb, adr_stb, dat_stb, rd_stb;
    logic tmr_start, tmr_wr, tmr_abort;
    logic hard_rst, go_status, go_id, go_array, load_col;
    logic cache_set, cache_clr, prot_fail, acnt_clr;
    logic collecting, adr_take, dat_take, col_step, id_step;

    logic [COL_W-1:0]  col_q, col_next, col_addr;
    logic [ACNT_W-1:0] acnt_q;
    logic [7:0]        a0_q, a1_q;
    logic [15:0]       col_raw;
    logic              fail_q, cache_q;
    logic [1:0]        id_q;
    logic [7:0]        buf_rd, status_byte;

    nfi_strobe u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .cle       (cle),
        .ale       (ale),
        .we_n      (we_n),
        .re_n      (re_n),
        .cmd_stb_o (cmd_stb),
        .adr_stb_o (adr_stb),
        .dat_stb_o (dat_stb),
        .rd_stb_o  (rd_stb)
    );

    nfi_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES),
        .WP_FILT_CYC (WP_FILT_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (tmr_start),
        .wr_op_i  (tmr_wr),
        .cancel_i (hard_rst),
        .wp_n_i   (wp_n),
        .busy_o   (busy),
        .abort_o  (tmr_abort)
    );

    nfi_page_buf #(
        .DEPTH (BUF_DEPTH),
        .AW    (BUF_AW)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (dat_take),
        .wr_idx_i  (col_q[BUF_AW-1:0]),
        .wr_data_i (io_in),
        .rd_idx_i  (col_q[BUF_AW-1:0]),
        .rd_data_o (buf_rd)
    );

    // column arithmetic
    assign col_raw  = {a1_q, a0_q};
    assign col_addr = (int'(col_raw) < COL_TOTAL) ? col_raw[COL_W-1:0] : '0;
    assign col_next = (col_q == COL_W'(COL_TOTAL - 1)) ? '0 : col_q + 1'b1;

    assign collecting = (st_q == ST_RD_ADDR) || (st_q == ST_PG_ADDR) ||
                        (st_q == ST_ER_ADDR) || (st_q == ST_COL_ADDR);
    assign adr_take   = adr_stb && !busy && collecting &&
                        (acnt_q != ACNT_W'(ADDR_CYC));
    assign dat_take   = dat_stb && !busy && (st_q == ST_PG_DATA);
    assign col_step   = dat_take || (rd_stb && !busy && mode_q == OUT_ARRAY);
    assign id_step    = rd_stb && (mode_q == OUT_IDENT) && (id_q != 2'd2);

    // sequencer decode
    always_comb begin
        st_n      = st_q;
        tmr_start = 1'b0;
        tmr_wr    = 1'b0;
        hard_rst  = 1'b0;
        go_status = 1'b0;
        go_id     = 1'b0;
        go_array  = 1'b0;
        load_col  = 1'b0;
        cache_set = 1'b0;
        cache_clr = 1'b0;
        prot_fail = 1'b0;
        acnt_clr  = 1'b0;
        if (cmd_stb) begin
            if (io_in == OP_RESET) begin
                hard_rst = 1'b1;
                st_n     = ST_IDLE;
            end else if (busy) begin
                if (io_in == OP_STATUS) go_status = 1'b1;
            end else if (st_q == ST_RD_CONF &&
                         (io_in == OP_READ_GO || io_in == OP_CACHE_GO)) begin
                st_n      = ST_IDLE;
                tmr_start = 1'b1;
                load_col  = 1'b1;
                go_array  = 1'b1;
                cache_set = (io_in == OP_CACHE_GO);
            end else if ((st_q == ST_PG_DATA && io_in == OP_PROG_GO) ||
                         (st_q == ST_ER_CONF && io_in == OP_ERASE_GO)) begin
                st_n = ST_IDLE;
                if (wp_n) begin
                    tmr_start = 1'b1;
                    tmr_wr    = 1'b1;
                end else begin
                    prot_fail = 1'b1;
                end
            end else if (st_q == ST_COL_CONF && io_in == OP_COL_GO) begin
                st_n     = ST_IDLE;
                load_col = 1'b1;
                go_array = 1'b1;
            end else begin
                case (io_in)
                    OP_READ: begin
                        st_n     = ST_RD_ADDR;
                        acnt_clr = 1'b1;
                        go_array = 1'b1;
                    end
                    OP_PROG: begin
                        st_n     = ST_PG_ADDR;
                        acnt_clr = 1'b1;
                    end
                    OP_ERASE: begin
                        st_n     = ST_ER_ADDR;
                        acnt_clr = 1'b1;
                    end
                    OP_COL: begin
                        if (cache_q) begin
                            st_n = ST_IDLE;
                        end else begin
                            st_n     = ST_COL_ADDR;
                            acnt_clr = 1'b1;
                        end
                    end
                    OP_STATUS: begin
                        st_n      = ST_IDLE;
                        go_status = 1'b1;
                    end
                    OP_IDENT: begin
                        st_n  = ST_IDLE;
                        go_id = 1'b1;
                    end
                    OP_CACHE_END: begin
                        if (cache_q) begin
                            st_n      = ST_IDLE;
                            tmr_start = 1'b1;
                            cache_clr = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (adr_take) begin
            unique case (st_q)
                ST_RD_ADDR:  if (acnt_q == ACNT_W'(ADDR_CYC - 1)) st_n = ST_RD_CONF;
                ST_ER_ADDR:  if (acnt_q == ACNT_W'(ADDR_CYC - 1)) st_n = ST_ER_CONF;
                ST_PG_ADDR: begin
                    if (acnt_q == ACNT_W'(ADDR_CYC - 1)) begin
                        st_n     = ST_PG_DATA;
                        load_col = 1'b1;
                    end
                end
                ST_COL_ADDR: if (acnt_q == ACNT_W'(COL_CYC - 1)) st_n = ST_COL_CONF;
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // output-side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= OUT_ARRAY;
            col_q   <= '0;
            acnt_q  <= '0;
            a0_q    <= 8'h00;
            a1_q    <= 8'h00;
            fail_q  <= 1'b0;
            cache_q <= 1'b0;
            id_q    <= 2'd0;
        end else if (hard_rst) begin
            mode_q  <= OUT_ARRAY;
            col_q   <= '0;
            acnt_q  <= '0;
            fail_q  <= 1'b0;
            cache_q <= 1'b0;
            id_q    <= 2'd0;
        end else begin
            if (go_status) mode_q <= OUT_STATUS;
            if (go_array)  mode_q <= OUT_ARRAY;
            if (go_id) begin
                mode_q <= OUT_IDENT;
                id_q   <= 2'd0;
            end else if (id_step) begin
                id_q <= id_q + 1'b1;
            end
            if (load_col)      col_q <= col_addr;
            else if (col_step) col_q <= col_next;
            if (cache_set) cache_q <= 1'b1;
            if (cache_clr) cache_q <= 1'b0;
            if (prot_fail || tmr_abort) fail_q <= 1'b1;
            else if (tmr_start && tmr_wr) fail_q <= 1'b0;
            if (acnt_clr) begin
                acnt_q <= '0;
            end else if (adr_take) begin
                acnt_q <= acnt_q + 1'b1;
                if (acnt_q == ACNT_W'(0)) a0_q <= io_in;
                if (acnt_q == ACNT_W'(1)) a1_q <= io_in;
            end
        end
    end

    assign status_byte = {wp_n, !busy, 5'b00000, fail_q};

    always_comb begin
        unique case (mode_q)
            OUT_STATUS: io_out = status_byte;
            OUT_IDENT:  io_out = (id_q == 2'd0) ? ID_MAKER :
                                 (id_q == 2'd1) ? ID_DEVICE : 8'h00;
            default:    io_out = buf_rd;
        endcase
    end

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(col_q) < COL_TOTAL); // R11

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && !op_known(io_in)) |-> !tmr_start); // R12

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |-> !busy); // R13

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OUT_STATUS && !cmd_stb) |=> (mode_q == OUT_STATUS)); // R2

endmodule

// File: tb/nand_cmd_front_test.sv
module nand_cmd_front_test;
    localparam int BUSY_N = 40;
    localparam int FILT_N = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b0;
    logic       cle = 1'b0;
    logic       ale = 1'b0;
    logic       we_n = 1'b1;
    logic       re_n = 1'b1;
    logic       wp_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic       busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nand_cmd_front #(
        .BUSY_CYCLES (BUSY_N),
        .WP_FILT_CYC (FILT_N)
    ) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .cle    (cle),
        .ale    (ale),
        .we_n   (we_n),
        .re_n   (re_n),
        .wp_n   (wp_n),
        .io_in  (io_in),
        .io_out (io_out),
        .busy   (busy)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 17 + 3) & 255);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk);
        cle = c; ale = a; io_in = b; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);  wr(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b);  wr(1'b0, 1'b1, b); endtask
    task automatic dat(input logic [7:0] b);  wr(1'b0, 1'b0, b); endtask

    task automatic addr5(input int col);
        adr(8'(col & 255));
        adr(8'((col >> 8) & 255));
        adr(8'h00); adr(8'h00); adr(8'h00);
    endtask

    task automatic col2(input int col);
        adr(8'(col & 255));
        adr(8'((col >> 8) & 255));
    endtask

    task automatic rd_pulse;
        @(negedge clk); re_n = 1'b0;
        @(negedge clk); re_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 data after reset", int'(io_out), 8'h00);
        cmd(8'h70);
        chk("R1 status after reset", int'(io_out), 8'hC0);
    endtask

    task automatic t_program;
        int n;
        cmd(8'h80); addr5(0);
        for (int i = 0; i < 16; i++) dat(pat(i));
        cmd(8'h10);
        chk("R4 busy after 10h", int'(busy), 1);
        chk("R2 status while busy", int'(io_out), 8'h80);
        wait_ready(n);
        chk("R4 program busy length", n, BUSY_N);
        chk("R2 status kept after program", int'(io_out), 8'hC0);
    endtask

    task automatic t_read;
        int n;
        cmd(8'h00); addr5(3); cmd(8'h30);
        wait_ready(n);
        chk("R3 read busy length", n, BUSY_N);
        chk("R3 first byte", int'(io_out), int'(pat(3)));
        rd_pulse();
        chk("R3 next byte", int'(io_out), int'(pat(4)));
    endtask

    task automatic t_ident;
        cmd(8'h90);
        chk("R8 maker byte", int'(io_out), 8'hAD);
        rd_pulse();
        chk("R8 device byte", int'(io_out), 8'hD3);
        rd_pulse();
        chk("R8 past end", int'(io_out), 8'h00);
        cmd(8'h00);
        chk("R2 00h returns to data", int'(io_out), int'(pat(4)));
    endtask

    task automatic t_column;
        cmd(8'h05); col2(9); cmd(8'hE0);
        chk("R6 column moved", int'(io_out), int'(pat(9)));
        chk("R6 no busy", int'(busy), 0);
    endtask

    task automatic t_wrap;
        cmd(8'h05); col2(2111); cmd(8'hE0);
        chk("R11 last column", int'(io_out), int'(pat(15)));
        rd_pulse();
        chk("R11 wrapped to 0", int'(io_out), int'(pat(0)));
        rd_pulse();
        chk("R11 column 1", int'(io_out), int'(pat(1)));
    endtask

    task automatic t_unknown;
        cmd(8'h70);
        cmd(8'h5A);
        chk("R12 status kept", int'(io_out), 8'hC0);
        chk("R12 no busy", int'(busy), 0);
        rd_pulse();
        chk("R2 status across read strobe", int'(io_out), 8'hC0);
        cmd(8'h00);
        cmd(8'hC3);
        chk("R12 data kept", int'(io_out), int'(pat(1)));
    endtask

    task automatic t_cache;
        int n;
        cmd(8'h00); addr5(2); cmd(8'h31);
        chk("R7 cache entry busy", int'(busy), 1);
        wait_ready(n);
        chk("R7 cache entry length", n, BUSY_N);
        chk("R7 cache data", int'(io_out), int'(pat(2)));
        cmd(8'h05); col2(7); cmd(8'hE0);
        chk("R6 refused in cache read", int'(io_out), int'(pat(2)));
        cmd(8'h34);
        chk("R7 exit busy", int'(busy), 1);
        wait_ready(n);
        cmd(8'h05); col2(7); cmd(8'hE0);
        chk("R7 column change after exit", int'(io_out), int'(pat(7)));
    endtask

    task automatic t_erase;
        int n;
        cmd(8'h70);
        cmd(8'h60); addr5(0); cmd(8'hD0);
        chk("R5 erase busy", int'(busy), 1);
        cmd(8'h90);
        wait_ready(n);
        chk("R5 erase length", n, BUSY_N - 3);
        chk("R13 90h ignored while busy", int'(io_out), 8'hC0);
        cmd(8'h00);
        chk("R5 buffer untouched", int'(io_out), int'(pat(7)));
    endtask

    task automatic t_reset_cmd;
        cmd(8'h80); addr5(0); cmd(8'h10);
        chk("R13 busy before FFh", int'(busy), 1);
        cmd(8'hFF);
        chk("R13 FFh clears busy", int'(busy), 0);
        chk("R13 FFh column 0", int'(io_out), int'(pat(0)));
    endtask

    task automatic t_protect;
        wp_n = 1'b0;
        cmd(8'h70);
        chk("R2 status wp low", int'(io_out), 8'h40);
        cmd(8'h80); addr5(0); dat(8'hEE); cmd(8'h10);
        chk("R9 no busy when protected", int'(busy), 0);
        chk("R9 fail set", int'(io_out), 8'h41);
        wp_n = 1'b1;
        @(negedge clk);
        chk("R9 fail sticky", int'(io_out), 8'hC1);
    endtask

    task automatic t_abort;
        int n;
        cmd(8'h60); addr5(0); cmd(8'hD0);
        chk("R9 fail cleared on start", int'(io_out), 8'h80);
        wp_n = 1'b0;
        repeat (FILT_N - 2) @(negedge clk);
        wp_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 short dip ignored", int'(busy), 1);
        wp_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 busy before filter", int'(busy), 1);
        repeat (FILT_N - 1) @(negedge clk);
        chk("R10 aborted", int'(busy), 0);
        chk("R10 fail after abort", int'(io_out), 8'h41);
        cmd(8'h00); addr5(0); cmd(8'h30);
        repeat (FILT_N + 4) @(negedge clk);
        chk("R10 read not aborted", int'(busy), 1);
        wp_n = 1'b1;
        wait_ready(n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_read();
        t_ident();
        t_column();
        t_wrap();
        t_unknown();
        t_cache();
        t_erase();
        t_reset_cmd();
        t_protect();
        t_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule